// File: doc/BRIEF.md
# Four-Lane TMDS Serializer Gearbox

This block converts three pre-encoded 10-bit channel symbols (red, green, blue) into four single-bit serial lanes. The fourth lane carries the pixel clock as a data-like lane. One symbol set arrives per pixel clock. The block registers it, splits each symbol into a lower and an upper 5-bit half on a double-rate clock, and shifts every half out one bit per cycle of a clock running at ten times the pixel rate. The forwarded clock lane sends five ones during the lower-half phase and five zeros during the upper-half phase. Its waveform therefore has the pixel-clock frequency.

The three clocks come from one source and are phase aligned. Every rising pixel edge coincides with a double-rate edge, and every double-rate edge coincides with a bit-clock edge. The synchronous reset must be released within the first half of a pixel period, after a pixel edge and before the next double-rate edge.

The half-word selector is a two-state machine:
- Reset forces it to PH_LOW.
- On each double-rate edge, PH_LOW loads the lower halves and moves to PH_HIGH.
- On the next double-rate edge, PH_HIGH loads the upper halves and returns to PH_LOW.

Top module: `tmds_lane_serializer`

## Requirements
- R1: The clock lane repeats the 10-bit pattern 0x01F continuously: five ones, then five zeros, in send order. Each pattern spans one pixel period.
- R2: Each data lane sends its 10-bit symbol least-significant bit first. Bit 0 is sent during the first of the clock lane's five ones.
- R3: Symbols appear on the lanes in the order they were applied, one per pixel period, with no gaps or repeats.
- R4: While reset is asserted, all four serial outputs are 0. The first word after reset is the all-zero symbol on every data lane.
- R5: The half-word state alternates PH_LOW, PH_HIGH on every double-rate edge. The first half after reset is the lower half, bits [4:0], paired with clock-lane ones. The upper half, bits [9:5], is paired with clock-lane zeros.
- R6: Each lane's shift register reloads exactly once every five bit-clock cycles, on the bit-clock edge after each double-rate edge, so bits follow one another without gaps.
- R7: Input symbols are registered on the pixel clock. A symbol that changes every pixel period is still sent intact in both halves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pix | input | 1 | Pixel clock |
| clk_half | input | 1 | Double-rate clock, phase aligned to clk_pix |
| clk_bit | input | 1 | Ten-times bit clock, phase aligned to clk_pix |
| rst | input | 1 | Synchronous active-high reset, sampled in every domain |
| sym_red | input | 10 | Encoded red symbol |
| sym_grn | input | 10 | Encoded green symbol |
| sym_blu | input | 10 | Encoded blue symbol |
| ser_clk | output | 1 | Forwarded clock lane |
| ser_red | output | 1 | Red serial lane |
| ser_grn | output | 1 | Green serial lane |
| ser_blu | output | 1 | Blue serial lane |

## Verification
The stimulus patterns each expose a different kind of fault:
- Constant all-zero and all-one symbols separate a stuck lane from a live one.
- Alternating 0x2AA/0x155 symbols and the four control-period symbols expose a swapped half or a reversed bit order.
- A walking one, rotated differently across the three lanes, pins down each bit position and catches lane crossing.
- A pseudo-random run, changing every pixel period, shows that both halves of a word come from the same symbol and that symbols are neither dropped nor repeated.

Every reassembled word is checked against the clock-lane pattern, and the reset window is checked for idle outputs.

// File: rtl/tmds_ser_pkg.sv
package tmds_ser_pkg;
    localparam int LANES    = 4;
    localparam int LANE_CLK = 0;
    localparam int DATA_LN  = LANES - 1;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_t;
endpackage

// File: rtl/sym_capture.sv
module sym_capture #(
    parameter int SYM_W = 10
) (
    input  logic                                     clk_pix,
    input  logic                                     rst,
    input  logic [SYM_W-1:0]                         sym_red,
    input  logic [SYM_W-1:0]                         sym_grn,
    input  logic [SYM_W-1:0]                         sym_blu,
    output logic [tmds_ser_pkg::DATA_LN-1:0][SYM_W-1:0] sym_q
);
    // Hold each symbol for a full pixel period so both halves match (R7)
    always_ff @(posedge clk_pix) begin
        if (rst) begin
            sym_q <= '0;
        end else begin
            sym_q[0] <= sym_red;
            sym_q[1] <= sym_grn;
            sym_q[2] <= sym_blu;
        end
    end
endmodule

// File: rtl/half_gearbox.sv
module half_gearbox
    import tmds_ser_pkg::*;
#(
    parameter int SYM_W  = 10,
    parameter int HALF_W = SYM_W / 2
) (
    input  logic                               clk_half,
    input  logic                               rst,
    input  logic [DATA_LN-1:0][SYM_W-1:0]      sym_q,
    output logic [LANES-1:0][HALF_W-1:0]       half_q
);
    phase_t state;

    // State register
    always_ff @(posedge clk_half) begin
        if (rst) begin
            state <= PH_LOW;
        end else begin
            unique case (state)
                PH_LOW:  state <= PH_HIGH;
                PH_HIGH: state <= PH_LOW;
            endcase
        end
    end

    // Output process: half-word buffers
    always_ff @(posedge clk_half) begin
        if (rst) begin
            half_q <= '0;
        end else begin
            unique case (state)
                PH_LOW: begin
                    half_q[LANE_CLK] <= {HALF_W{1'b1}};
                    for (int i = 0; i < DATA_LN; i++) begin
                        half_q[i+1] <= sym_q[i][HALF_W-1:0];
                    end
                end
                PH_HIGH: begin
                    half_q[LANE_CLK] <= '0;
                    for (int i = 0; i < DATA_LN; i++) begin
                        half_q[i+1] <= sym_q[i][SYM_W-1:HALF_W];
                    end
                end
            endcase
        end
    end

    // R5
    phase_alt_chk: assert property (@(posedge clk_half) disable iff (rst)
        (state == PH_LOW) |=> (state == PH_HIGH));
    // R1
    clk_ones_then_zeros_chk: assert property (@(posedge clk_half) disable iff (rst)
        (half_q[LANE_CLK] == {HALF_W{1'b1}}) |=> (half_q[LANE_CLK] == '0));
    // R1
    clk_zeros_then_ones_chk: assert property (@(posedge clk_half) disable iff (rst)
        (half_q[LANE_CLK] == '0) |=> (half_q[LANE_CLK] == {HALF_W{1'b1}}));
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
    parameter int HALF_W = 5
) (
    input  logic              clk_bit,
    input  logic              rst,
    input  logic [HALF_W-1:0] word,
    output logic              ser
);
    localparam int CW = (HALF_W > 1) ? $clog2(HALF_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_W - 1);

    logic [CW-1:0]     cnt;
    logic [HALF_W-1:0] sh;
    logic              ld;

    assign ld = (cnt == '0);

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            sh <= '0;
        end else if (ld) begin
            sh <= word;
        end else begin
            sh <= {1'b0, sh[HALF_W-1:1]};
        end
    end

    assign ser = sh[0];

    // R6
    no_double_load_chk: assert property (@(posedge clk_bit) disable iff (rst)
        ld |=> !ld);
endmodule

// File: rtl/tmds_lane_serializer.sv
module tmds_lane_serializer
    import tmds_ser_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic             clk_pix,
    input  logic             clk_half,
    input  logic             clk_bit,
    input  logic             rst,
    input  logic [SYM_W-1:0] sym_red,
    input  logic [SYM_W-1:0] sym_grn,
    input  logic [SYM_W-1:0] sym_blu,
    output logic             ser_clk,
    output logic             ser_red,
    output logic             ser_grn,
    output logic             ser_blu
);
    localparam int HALF_W = SYM_W / 2;

    logic [DATA_LN-1:0][SYM_W-1:0] sym_q;
    logic [LANES-1:0][HALF_W-1:0]  half_q;
    logic [LANES-1:0]              ser_v;

    sym_capture #(.SYM_W(SYM_W)) cap_i (
        .clk_pix (clk_pix),
        .rst     (rst),
        .sym_red (sym_red),
        .sym_grn (sym_grn),
        .sym_blu (sym_blu),
        .sym_q   (sym_q)
    );

    half_gearbox #(.SYM_W(SYM_W), .HALF_W(HALF_W)) gear_i (
        .clk_half (clk_half),
        .rst      (rst),
        .sym_q    (sym_q),
        .half_q   (half_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_shifter #(.HALF_W(HALF_W)) shf_i (
            .clk_bit (clk_bit),
            .rst     (rst),
            .word    (half_q[g]),
            .ser     (ser_v[g])
        );
    end

    assign ser_clk = ser_v[LANE_CLK];
    assign ser_red = ser_v[1];
    assign ser_grn = ser_v[2];
    assign ser_blu = ser_v[3];

    // R4
    idle_in_reset_chk: assert property (@(posedge clk_bit)
        $past(rst) |-> (ser_v == '0));
endmodule

// File: tb/tmds_lane_serializer_tb_top.sv
`timescale 1ns/100ps
module tmds_lane_serializer_tb_top;
    logic clk_pix, clk_half, clk_bit, rst;
    logic [9:0] sym_red, sym_grn, sym_blu;
    logic ser_clk, ser_red, ser_grn, ser_blu;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;
    logic [29:0] exp_q[$];

    tmds_lane_serializer dut_i (
        .clk_pix(clk_pix), .clk_half(clk_half), .clk_bit(clk_bit), .rst(rst),
        .sym_red(sym_red), .sym_grn(sym_grn), .sym_blu(sym_blu),
        .ser_clk(ser_clk), .ser_red(ser_red), .ser_grn(ser_grn), .ser_blu(ser_blu)
    );

    // One source for all three clocks: pixel 50 MHz, half 100 MHz, bit 500 MHz
    int unsigned tick = 0;
    initial begin
        clk_bit = 1; clk_half = 1; clk_pix = 1;
        forever begin
            #1;
            tick++;
            clk_bit  = (tick % 2) == 0;
            clk_half = (tick % 10) < 5;
            clk_pix  = (tick % 20) < 10;
        end
    end

    task automatic check(input bit ok, input string what,
                         input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic send(input logic [9:0] r, input logic [9:0] g, input logic [9:0] b);
        sym_red = r; sym_grn = g; sym_blu = b;
        exp_q.push_back({b, g, r});
        #20;
    endtask

    // Monitor: rebuild words LSB first, aligned on the first clock-lane one
    bit started = 0;
    int idx = 0;
    logic [9:0] wc, wr, wg, wb;
    always @(negedge clk_bit) begin
        if (rst) begin
            started = 0;
            idx = 0;
        end else begin
            if (!started && ser_clk) started = 1;
            if (started) begin
                wc[idx] = ser_clk; wr[idx] = ser_red;
                wg[idx] = ser_grn; wb[idx] = ser_blu;
                idx++;
                if (idx == 10) begin
                    logic [29:0] e;
                    idx = 0;
                    // R1 R5: ones on the lower half, zeros on the upper half
                    check(wc == 10'h01F, "R1 R5 clock lane pattern", wc, 10'h01F);
                    if (exp_q.size() > 0) begin
                        e = exp_q.pop_front();
                        // R2 R3 R6 R7: every lane word in order, LSB first
                        check(wr == e[9:0],   "R2 R3 R6 R7 red lane",   wr, e[9:0]);
                        check(wg == e[19:10], "R2 R3 R6 R7 green lane", wg, e[19:10]);
                        check(wb == e[29:20], "R2 R3 R6 R7 blue lane",  wb, e[29:20]);
                    end
                end
            end
        end
    end

    initial begin
        logic [9:0] lfsr;
        rst = 1;
        sym_red = '0; sym_grn = '0; sym_blu = '0;
        #99.5;
        // R4: lanes idle during reset
        check({ser_clk, ser_red, ser_grn, ser_blu} == 4'b0, "R4 outputs in reset",
              {6'b0, ser_clk, ser_red, ser_grn, ser_blu}, 10'h000);
        #1;
        rst = 0;
        // R4: first word after reset carries the cleared symbol
        exp_q.push_back(30'h0);
        send(10'h000, 10'h000, 10'h000);
        send(10'h3FF, 10'h3FF, 10'h3FF);
        send(10'h2AA, 10'h155, 10'h2AA);
        send(10'h155, 10'h2AA, 10'h155);
        send(10'h354, 10'h0AB, 10'h154);
        send(10'h2AB, 10'h354, 10'h0AB);
        for (int i = 0; i < 10; i++) begin
            send(10'(1 << i), 10'(1 << ((i + 3) % 10)), 10'(1 << ((i + 7) % 10)));
        end
        lfsr = 10'h2C5;
        for (int i = 0; i < 16; i++) begin
            logic [9:0] a, b2, c;
            lfsr = {lfsr[8:0], lfsr[9] ^ lfsr[6]}; a  = lfsr;
            lfsr = {lfsr[8:0], lfsr[9] ^ lfsr[6]}; b2 = lfsr;
            lfsr = {lfsr[8:0], lfsr[9] ^ lfsr[6]}; c  = lfsr;
            send(a, b2 ^ 10'h1A5, c);
        end
        #200;
        // R3: every applied symbol came out
        check(exp_q.size() == 0, "R3 all words delivered",
              10'(exp_q.size()), 10'h000);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog expired actual=%h expected=%h", 10'h000, 10'h001);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule